// File: doc/BRIEF.md
# Specifier-Addressed Register File

This block is the working-register store of a small 8-bit accumulator-style processor. It keeps seven 8-bit registers, each selected by a 3-bit specifier taken straight from an instruction word. A single synchronous write port loads a register. Two combinational read ports return register contents in the same cycle.

The specifier space has eight codes, but one code (110) names memory rather than a register. Any write, read or copy that uses that code is rejected and flagged, and no register is changed by it.

A copy helper takes a packed 6-bit field, with the destination specifier in the upper three bits and the source specifier in the lower three. It moves one register into another on a single clock edge. When a direct write and a copy are requested together, the write wins.

Top module: `spec_regfile`

## Requirements
- R1: Specifier codes map to registers as follows: 000 is B, 001 is C, 010 is D, 011 is E, 100 is H, 101 is L and 111 is A. When the write enable is high with a register code, the write data is stored in that register at the rising clock edge.
- R2: A direct write with specifier 110 changes no register, and `op_bad` is high during that cycle.
- R3: The read ports are combinational. A read of a register in the cycle it is written returns the old value, and the new value is returned from the cycle after the edge.
- R4: A read with specifier 110 returns zero, and that port's `bad` output is high. A read with any register code keeps `bad` low.
- R5: In a copy, field bits [5:3] select the destination and bits [2:0] select the source. On the rising edge, the destination receives the value the source held before that edge.
- R6: A copy whose destination field, source field, or both equal 110 changes no register, and `op_bad` is high during that cycle.
- R7: A copy whose destination equals its source (a register code) leaves the value unchanged and keeps `op_bad` low.
- R8: When `wr_en` and `cp_en` are both high, only the direct write takes effect, and `op_bad` reflects only the write specifier.
- R9: An active-high reset clears every register to zero as soon as it is asserted, without waiting for a clock edge.
- R10: The two read ports select and return registers independently of each other in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and copies take effect on the rising edge |
| rst | input | 1 | Asynchronous active-high reset, clears all registers |
| wr_en | input | 1 | Direct write request |
| wr_sel | input | 3 | Direct write specifier |
| wr_data | input | 8 | Direct write data |
| cp_en | input | 1 | Register copy request |
| cp_field | input | 6 | Copy field: [5:3] destination, [2:0] source |
| op_bad | output | 1 | Current write or copy uses the memory code and is rejected |
| ra_sel | input | 3 | Read port A specifier |
| ra_data | output | 8 | Read port A data |
| ra_bad | output | 1 | Read port A specifier is the memory code |
| rb_sel | input | 3 | Read port B specifier |
| rb_data | output | 8 | Read port B data |
| rb_bad | output | 1 | Read port B specifier is the memory code |

## Verification
The flags and read data are combinational, so the bench checks them in the same cycle the stimulus is applied, before the clock edge. Stored results from a write or copy are due one edge later. The bench drives inputs on the falling edge and checks the same-cycle values shortly after driving them. After the rising edge it drops the enables and then sweeps both read ports over all eight codes to compare every register with its own model. Reset is checked between edges, right after it is asserted, to show that clearing does not wait for a clock.

// File: rtl/spec_rf_pkg.sv
package spec_rf_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned SEL_W_DEF  = 3;
  localparam logic [2:0]  MEM_CODE_DEF = 3'b110;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_COPY  = 2'd2
  } rf_op_e;
endpackage

// File: rtl/spec_decode.sv
module spec_decode #(
  parameter int unsigned SEL_W = 3,
  parameter logic [SEL_W-1:0] MEM_CODE = 3'b110,
  localparam int unsigned NSLOT = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NSLOT-1:0] hit,
  output logic             is_mem
);
  assign is_mem = (sel == MEM_CODE);

  for (genvar i = 0; i < NSLOT; i++) begin : g_hit
    if (i == int'(MEM_CODE)) begin : g_none
      assign hit[i] = 1'b0;
    end else begin : g_reg
      assign hit[i] = en && (sel == SEL_W'(i));
    end
  end
endmodule

// File: rtl/spec_read_mux.sv
module spec_read_mux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W = 3,
  parameter logic [SEL_W-1:0] MEM_CODE = 3'b110,
  localparam int unsigned NSLOT = 1 << SEL_W
) (
  input  logic [NSLOT-1:0][DATA_W-1:0] slots,
  input  logic [SEL_W-1:0]             sel,
  output logic [DATA_W-1:0]            data,
  output logic                         bad
);
  always_comb begin
    bad  = (sel == MEM_CODE);
    data = bad ? '0 : slots[sel];
  end

  always_comb begin
    if (sel == MEM_CODE) assert_mem_read_zero_R4: assert (data == '0 && bad);
  end
endmodule

// File: rtl/spec_regfile.sv
module spec_regfile
  import spec_rf_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned SEL_W  = SEL_W_DEF,
  parameter logic [SEL_W-1:0] MEM_CODE = MEM_CODE_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                cp_en,
  input  logic [2*SEL_W-1:0]  cp_field,
  output logic                op_bad,
  input  logic [SEL_W-1:0]    ra_sel,
  output logic [DATA_W-1:0]   ra_data,
  output logic                ra_bad,
  input  logic [SEL_W-1:0]    rb_sel,
  output logic [DATA_W-1:0]   rb_data,
  output logic                rb_bad
);
  localparam int unsigned NSLOT = 1 << SEL_W;

  logic [NSLOT-1:0][DATA_W-1:0] slot_q;
  logic [SEL_W-1:0]  cp_dst, cp_src;
  logic [DATA_W-1:0] cp_data;
  logic              cp_src_mem;
  rf_op_e            op_sel;
  logic              tgt_en;
  logic [SEL_W-1:0]  tgt_sel;
  logic [DATA_W-1:0] tgt_data;
  logic [NSLOT-1:0]  slot_we;
  logic              tgt_mem;

  assign cp_dst = cp_field[2*SEL_W-1:SEL_W];
  assign cp_src = cp_field[SEL_W-1:0];

  spec_read_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .MEM_CODE(MEM_CODE)) i_mux_a (
    .slots(slot_q), .sel(ra_sel), .data(ra_data), .bad(ra_bad));
  spec_read_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .MEM_CODE(MEM_CODE)) i_mux_b (
    .slots(slot_q), .sel(rb_sel), .data(rb_data), .bad(rb_bad));
  spec_read_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .MEM_CODE(MEM_CODE)) i_mux_cp (
    .slots(slot_q), .sel(cp_src), .data(cp_data), .bad(cp_src_mem));

  // next-state selection: direct write has priority over copy
  always_comb begin
    op_sel   = OP_NONE;
    tgt_sel  = wr_sel;
    tgt_data = wr_data;
    tgt_en   = 1'b0;
    if (wr_en) begin
      op_sel = OP_WRITE;
      tgt_en = 1'b1;
    end else if (cp_en) begin
      op_sel   = OP_COPY;
      tgt_sel  = cp_dst;
      tgt_data = cp_data;
      tgt_en   = !cp_src_mem;
    end
  end

  spec_decode #(.SEL_W(SEL_W), .MEM_CODE(MEM_CODE)) i_dec (
    .en(tgt_en), .sel(tgt_sel), .hit(slot_we), .is_mem(tgt_mem));

  always_comb begin
    unique case (op_sel)
      OP_WRITE: op_bad = tgt_mem;
      OP_COPY:  op_bad = tgt_mem || cp_src_mem;
      default:  op_bad = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i == int'(MEM_CODE)) begin : g_mem
      assign slot_q[i] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or posedge rst) begin
        if (rst)             q <= '0;
        else if (slot_we[i]) q <= tgt_data;
      end
      assign slot_q[i] = q;
    end
  end

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel != MEM_CODE) |=> slot_q[$past(wr_sel)] == $past(wr_data));

  assert_mem_write_inert_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == MEM_CODE) |=> $stable(slot_q));

  assert_copy_moves_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && cp_en && cp_dst != MEM_CODE && cp_src != MEM_CODE)
      |=> slot_q[$past(cp_dst)] == $past(slot_q[cp_src]));

  assert_bad_copy_inert_R6: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && cp_en && (cp_dst == MEM_CODE || cp_src == MEM_CODE))
      |=> $stable(slot_q));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cp_en) |-> (op_bad == (wr_sel == MEM_CODE)));
endmodule

// File: tb/test_spec_regfile.sv
module test_spec_regfile;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, cp_en;
  logic [2:0] wr_sel, ra_sel, rb_sel;
  logic [7:0] wr_data;
  logic [5:0] cp_field;
  logic op_bad, ra_bad, rb_bad;
  logic [7:0] ra_data, rb_data;

  logic [7:0] model [8];
  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_regfile i_spec_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cp_en(cp_en), .cp_field(cp_field), .op_bad(op_bad),
    .ra_sel(ra_sel), .ra_data(ra_data), .ra_bad(ra_bad),
    .rb_sel(rb_sel), .rb_data(rb_data), .rb_bad(rb_bad));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int s = 0; s < 8; s++) begin
      ra_sel = 3'(s);
      rb_sel = 3'(7 - s);
      #1;
      check({req, " R4 porta-data"}, ra_data, (s == 6) ? 8'h00 : model[s]);
      check({req, " R4 porta-bad"}, {7'd0, ra_bad}, {7'd0, s == 6});
      check({req, " R10 portb-data"}, rb_data, (7 - s == 6) ? 8'h00 : model[7 - s]);
      check({req, " R10 portb-bad"}, {7'd0, rb_bad}, {7'd0, 7 - s == 6});
    end
  endtask

  // one operation: drive on falling edge, check same-cycle flag and old read, update model after edge
  task automatic do_op(string req, logic we, logic [2:0] ws, logic [7:0] wd,
                       logic ce, logic [5:0] cf);
    logic exp_bad;
    logic [2:0] tgt;
    logic [7:0] nv;
    logic apply;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd; cp_en = ce; cp_field = cf;
    apply = 1'b0; tgt = ws; nv = wd; exp_bad = 1'b0;
    if (we) begin
      exp_bad = (ws == 3'd6);
      apply = !exp_bad;
    end else if (ce) begin
      tgt = cf[5:3];
      nv = model[cf[2:0]];
      exp_bad = (cf[5:3] == 3'd6) || (cf[2:0] == 3'd6);
      apply = !exp_bad;
    end
    ra_sel = tgt;
    #1;
    check({req, " op_bad"}, {7'd0, op_bad}, {7'd0, exp_bad});
    check({req, " R3 same-cycle old"}, ra_data, (tgt == 3'd6) ? 8'h00 : model[tgt]);
    @(posedge clk);
    if (apply) model[tgt] = nv;
    @(negedge clk);
    wr_en = 1'b0; cp_en = 1'b0;
    check_all(req);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; cp_en = 1'b0; wr_sel = '0; wr_data = '0;
    cp_field = '0; ra_sel = '0; rb_sel = '0;
    for (int s = 0; s < 8; s++) model[s] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R9 reset");

    // R1 and R3: write each register code with a distinct value
    for (int s = 0; s < 8; s++) begin
      if (s != 6) do_op("R1 write", 1'b1, 3'(s), 8'((s * 29) + 7), 1'b0, '0);
    end
    // R2: writes using the memory code
    do_op("R2 mem write", 1'b1, 3'd6, 8'hA5, 1'b0, '0);
    do_op("R2 mem write ff", 1'b1, 3'd6, 8'hFF, 1'b0, '0);

    // R5, R6, R7: exhaustive copy field sweep with a fresh source value each time
    for (int f = 0; f < 64; f++) begin
      if ((f % 8) != 6) do_op("R1 reload", 1'b1, 3'(f % 8), 8'((f * 37) + 11), 1'b0, '0);
      if ((f / 8) == (f % 8) && (f % 8) != 6)
        do_op("R7 self copy", 1'b0, '0, '0, 1'b1, 6'(f));
      else if ((f / 8) == 6 || (f % 8) == 6)
        do_op("R6 mem copy", 1'b0, '0, '0, 1'b1, 6'(f));
      else
        do_op("R5 copy", 1'b0, '0, '0, 1'b1, 6'(f));
    end

    // R8: write and copy together
    do_op("R8 write wins", 1'b1, 3'd7, 8'h3C, 1'b1, 6'b000_111);
    do_op("R8 mem write wins", 1'b1, 3'd6, 8'h99, 1'b1, 6'b001_000);
    do_op("R8 write over bad copy", 1'b1, 3'd2, 8'h5A, 1'b1, 6'b110_110);

    // R9: asynchronous reset between edges
    @(negedge clk);
    #2;
    rst = 1'b1;
    #1;
    for (int s = 0; s < 8; s++) model[s] = 8'h00;
    check_all("R9 async clear");
    @(negedge clk);
    rst = 1'b0;
    do_op("R1 after reset", 1'b1, 3'd0, 8'h42, 1'b0, '0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule